// File: doc/BRIEF.md
# Receive Code-Group Decoder with Frame Delimiting

This block sits after code-group alignment in a 100 Mb/s receive path. It accepts one aligned 5-bit code-group per clock and produces a nibble-wide receive interface of the MII type: a 4-bit data nibble, a data-valid flag, an error flag and a carrier flag. A start delimiter that follows line idle becomes two preamble nibbles. Data code-groups are translated through a fixed 5-to-4 table until the stream is closed, either by the end delimiter pair or by two idle code-groups.

A burst of activity that leaves idle without the proper start pair is reported as a bad start-of-stream. The block then drives a fixed error nibble with the error flag set for every code-group until the line returns to idle. The decoder looks one code-group ahead to recognise delimiter pairs, so every output slot belongs to the code-group that entered two clock edges earlier.

Top module: `rx54_decoder`

## Requirements
- R1: While reset is asserted and until the first non-idle code-group, rxd is 0000 and rx_dv, rx_er and crs are all 0.
- R2: The idle code-group is 11111. A line carrying only idle code-groups keeps rxd at 0000 and rx_dv, rx_er and crs at 0.
- R3: The start pair is 11000 followed by 10001. When it follows idle, the two slots of the pair each output rxd 0101 with rx_dv 1, crs 1, rx_er 0.
- R4: Inside a frame each data code-group is output as its nibble with rx_dv 1, crs 1, rx_er 0, two clock edges after it was presented. Table, nibble 0 to F: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: Inside a frame any code-group outside the data table (including a single idle, and 01101 not followed by 00111) outputs rxd 0000 with rx_er 1, rx_dv 1, crs 1.
- R6: The end pair is 01101 followed by 00111. Its two slots output rxd 0000 with rx_dv, rx_er and crs all 0, and the frame is closed.
- R7: Inside a frame, two consecutive idle code-groups close the frame; the slot of the first idle and all later idle slots output all zeros.
- R8: Outside a frame, a non-idle code-group that does not begin the start pair is a bad start: its slot and every following slot output rxd 1110 with rx_er 1, crs 1, rx_dv 0.
- R9: A bad-start condition ends once two consecutive idle code-groups arrive; from the slot of the first of them rx_er and crs are 0, and a later start pair opens a normal frame.
- R10: An end pair followed at once by a start pair opens a new frame without intervening idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock, one aligned code-group per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cg_in | input | 5 | Aligned received code-group |
| rxd | output | 4 | Decoded receive nibble |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| crs | output | 1 | Carrier present |

## Verification
The bench sweeps all 32 code-group values in two places: as the first symbol after the start pair, and as the first non-idle symbol after idle. A decoder with a wrong table entry shows a wrong nibble, one that trusts a single delimiter symbol ends a frame on a lone 01101 or opens one on a lone 11000, and one that treats a single idle as the end drops rx_dv mid-frame. Recovery from a bad start through one idle (which must stay in error) and then two idles is exercised, as are back-to-back frames joined end pair to start pair, where a decoder that insists on idle before the start pair would report a bad start.

// File: rtl/rx54_pkg.sv
package rx54_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_PRE  = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_BAD  = 4'b1110;
  localparam logic [NIB_W-1:0] NIB_NONE = '0;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_KSLOT = 3'd1,
    ST_DATA  = 3'd2,
    ST_RSLOT = 3'd3,
    ST_BAD   = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic             is_data;
    logic [NIB_W-1:0] nib;
    logic             is_idle;
    logic             is_j;
    logic             is_t;
  } cg_info_t;
endpackage

// File: rtl/rx54_rst_sync.sv
module rx54_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rx54_cg_class.sv
module rx54_cg_class
  import rx54_pkg::*;
(
  input  logic [CG_W-1:0] cg,
  output cg_info_t        info
);
  always_comb begin
    info         = '0;
    info.is_data = 1'b1;
    unique case (cg)
      5'b11110: info.nib = 4'h0;
      5'b01001: info.nib = 4'h1;
      5'b10100: info.nib = 4'h2;
      5'b10101: info.nib = 4'h3;
      5'b01010: info.nib = 4'h4;
      5'b01011: info.nib = 4'h5;
      5'b01110: info.nib = 4'h6;
      5'b01111: info.nib = 4'h7;
      5'b10010: info.nib = 4'h8;
      5'b10011: info.nib = 4'h9;
      5'b10110: info.nib = 4'hA;
      5'b10111: info.nib = 4'hB;
      5'b11010: info.nib = 4'hC;
      5'b11011: info.nib = 4'hD;
      5'b11100: info.nib = 4'hE;
      5'b11101: info.nib = 4'hF;
      default:  info.is_data = 1'b0;
    endcase
    info.is_idle = (cg == CG_IDLE);
    info.is_j    = (cg == CG_J);
    info.is_t    = (cg == CG_T);
  end
endmodule

// File: rtl/rx54_fsm.sv
module rx54_fsm
  import rx54_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cg_info_t         prev,
  input  logic [CG_W-1:0]  cur_cg,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             crs
);
  rx_state_e        st_q, st_d;
  logic [NIB_W-1:0] rxd_d;
  logic             dv_d, er_d, crs_d;
  logic             cur_idle, cur_k, cur_r;
  logic             pair_jk, pair_tr, pair_ii;

  assign cur_idle = (cur_cg == CG_IDLE);
  assign cur_k    = (cur_cg == CG_K);
  assign cur_r    = (cur_cg == CG_R);
  assign pair_jk  = prev.is_j && cur_k;
  assign pair_tr  = prev.is_t && cur_r;
  assign pair_ii  = prev.is_idle && cur_idle;

  // next-state and next-output
  always_comb begin
    st_d  = st_q;
    rxd_d = NIB_NONE;
    dv_d  = 1'b0;
    er_d  = 1'b0;
    crs_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!prev.is_idle) begin
          crs_d = 1'b1;
          if (pair_jk) begin
            st_d  = ST_KSLOT;
            rxd_d = NIB_PRE;
            dv_d  = 1'b1;
          end else begin
            st_d  = ST_BAD;
            rxd_d = NIB_BAD;
            er_d  = 1'b1;
          end
        end
      end
      ST_KSLOT: begin
        st_d  = ST_DATA;
        rxd_d = NIB_PRE;
        dv_d  = 1'b1;
        crs_d = 1'b1;
      end
      ST_DATA: begin
        if (pair_tr) begin
          st_d = ST_RSLOT;
        end else if (pair_ii) begin
          st_d = ST_IDLE;
        end else begin
          dv_d  = 1'b1;
          crs_d = 1'b1;
          if (prev.is_data) rxd_d = prev.nib;
          else              er_d  = 1'b1;
        end
      end
      ST_RSLOT: st_d = ST_IDLE;
      ST_BAD: begin
        if (pair_ii) begin
          st_d = ST_IDLE;
        end else begin
          rxd_d = NIB_BAD;
          er_d  = 1'b1;
          crs_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rxd   <= NIB_NONE;
      rx_dv <= 1'b0;
      rx_er <= 1'b0;
      crs   <= 1'b0;
    end else begin
      st_q  <= st_d;
      rxd   <= rxd_d;
      rx_dv <= dv_d;
      rx_er <= er_d;
      crs   <= crs_d;
    end
  end

  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && prev.is_idle) |=> (!crs && !rx_dv && !rx_er));

  assert_preamble_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> (rxd == NIB_PRE && !rx_er));

  assert_preamble_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |=> (rx_dv && rxd == NIB_PRE));

  assert_dv_has_carrier_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv |-> crs);

  assert_end_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RSLOT) |-> (!rx_dv && !crs && !rx_er));

  assert_bad_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !rx_dv) |-> (rxd == NIB_BAD && crs));

  assert_error_has_carrier_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> crs);
endmodule

// File: rtl/rx54_decoder.sv
module rx54_decoder
  import rx54_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CG_W-1:0]  cg_in,
  output logic [NIB_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             crs
);
  logic            rst_s_n;
  logic [CG_W-1:0] prev_cg_q;
  cg_info_t        prev_info;

  rx54_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  // one code-group of lookahead
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) prev_cg_q <= CG_IDLE;
    else          prev_cg_q <= cg_in;
  end

  rx54_cg_class u_class (
    .cg   (prev_cg_q),
    .info (prev_info)
  );

  rx54_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .prev   (prev_info),
    .cur_cg (cg_in),
    .rxd    (rxd),
    .rx_dv  (rx_dv),
    .rx_er  (rx_er),
    .crs    (crs)
  );
endmodule

// File: tb/tb_rx54_decoder.sv
`timescale 1ns/1ps
module tb_rx54_decoder;
  localparam logic [4:0] I_CG = 5'b11111;
  localparam logic [4:0] J_CG = 5'b11000;
  localparam logic [4:0] K_CG = 5'b10001;
  localparam logic [4:0] T_CG = 5'b01101;
  localparam logic [4:0] R_CG = 5'b00111;

  logic       clk;
  logic       rst_n;
  logic [4:0] cg_in;
  logic [3:0] rxd;
  logic       rx_dv, rx_er, crs;

  int checks = 0;
  int errors = 0;

  logic [4:0] seq [64];
  int         seq_n;
  logic [6:0] exp_out [64];
  string      exp_tag [64];

  rx54_decoder dut (
    .clk(clk), .rst_n(rst_n), .cg_in(cg_in),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .crs(crs)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [4:0] enc(input int n);
    case (n)
      0: enc = 5'b11110;  1: enc = 5'b01001;  2: enc = 5'b10100;  3: enc = 5'b10101;
      4: enc = 5'b01010;  5: enc = 5'b01011;  6: enc = 5'b01110;  7: enc = 5'b01111;
      8: enc = 5'b10010;  9: enc = 5'b10011; 10: enc = 5'b10110; 11: enc = 5'b10111;
      12: enc = 5'b11010; 13: enc = 5'b11011; 14: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  function automatic int dec(input logic [4:0] c);
    dec = -1;
    for (int k = 0; k < 16; k++) if (enc(k) == c) dec = k;
  endfunction

  task automatic push(input logic [4:0] c);
    seq[seq_n] = c;
    seq_n++;
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // expected outputs {rxd, dv, er, crs} per slot, from the requirements
  task automatic model;
    int mode = 0; // 0 line idle, 1 second preamble, 2 in frame, 3 end second slot, 4 bad start
    for (int i = 0; i < seq_n; i++) begin
      logic [4:0] p = seq[i];
      logic [4:0] c = (i + 1 < seq_n) ? seq[i+1] : I_CG;
      logic [6:0] e = 7'b0;
      string t = "R2";
      case (mode)
        0: if (p != I_CG) begin
             if (p == J_CG && c == K_CG) begin e = {4'b0101, 3'b101}; mode = 1; t = "R3"; end
             else begin e = {4'b1110, 3'b011}; mode = 4; t = "R8"; end
           end
        1: begin e = {4'b0101, 3'b101}; mode = 2; t = "R3"; end
        2: if (p == T_CG && c == R_CG) begin mode = 3; t = "R6"; end
           else if (p == I_CG && c == I_CG) begin mode = 0; t = "R7"; end
           else if (dec(p) >= 0) begin e = {dec(p) & 4'hF, 3'b101}; t = "R4"; end
           else begin e = {4'b0000, 3'b111}; t = "R5"; end
        3: begin mode = 0; t = "R6"; end
        default: if (p == I_CG && c == I_CG) begin mode = 0; t = "R9"; end
                 else begin e = {4'b1110, 3'b011}; t = "R8"; end
      endcase
      exp_out[i] = e;
      exp_tag[i] = t;
    end
  endtask

  task automatic run_seq(input string tag_override);
    model();
    for (int i = 0; i < seq_n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        logic [6:0] act = {rxd, rx_dv, rx_er, crs};
        string t = (tag_override != "") ? tag_override : exp_tag[i-2];
        checks++;
        if (act !== exp_out[i-2]) begin
          errors++;
          $display("FAIL %s slot %0d: got rxd=%b dv=%b er=%b crs=%b expected rxd=%b dv=%b er=%b crs=%b",
                   t, i-2, act[6:3], act[2], act[1], act[0],
                   exp_out[i-2][6:3], exp_out[i-2][2], exp_out[i-2][1], exp_out[i-2][0]);
        end
      end
      cg_in = (i < seq_n) ? seq[i] : I_CG;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cg_in = J_CG;
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if ({rxd, rx_dv, rx_er, crs} !== 7'b0) begin
      errors++;
      $display("FAIL R1: got %b expected 0000000", {rxd, rx_dv, rx_er, crs});
    end
    cg_in = I_CG;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++; // R1 after release with idle line
    if ({rxd, rx_dv, rx_er, crs} !== 7'b0) begin
      errors++;
      $display("FAIL R1: got %b expected 0000000", {rxd, rx_dv, rx_er, crs});
    end

    // R2 idle line
    seq_n = 0;
    for (int k = 0; k < 6; k++) push(I_CG);
    run_seq("R2");

    // R3 R4 R6 all sixteen data code-groups in one frame
    seq_n = 0;
    push(I_CG); push(I_CG); push(J_CG); push(K_CG);
    for (int k = 0; k < 16; k++) push(enc(k));
    push(T_CG); push(R_CG); push(I_CG); push(I_CG); push(I_CG);
    run_seq("");

    // R5 sweep every code-group as the first frame symbol
    for (int v = 0; v < 32; v++) begin
      seq_n = 0;
      push(I_CG); push(I_CG); push(J_CG); push(K_CG);
      push(5'(v)); push(enc(5)); push(T_CG); push(R_CG);
      push(I_CG); push(I_CG); push(I_CG);
      run_seq("");
    end

    // R7 frame closed by two idles
    seq_n = 0;
    push(I_CG); push(I_CG); push(J_CG); push(K_CG);
    push(enc(3)); push(enc(9)); push(I_CG); push(I_CG); push(I_CG); push(I_CG);
    run_seq("");

    // R8 sweep every non-idle code-group as the first symbol after idle
    for (int v = 0; v < 31; v++) begin
      seq_n = 0;
      push(I_CG); push(I_CG); push(5'(v)); push(enc(2));
      push(I_CG); push(enc(7)); push(I_CG); push(I_CG); push(I_CG);
      run_seq("");
    end

    // R9 recovery from bad start then a clean frame
    seq_n = 0;
    push(I_CG); push(I_CG); push(enc(1)); push(I_CG); push(I_CG);
    push(J_CG); push(K_CG); push(enc(4)); push(T_CG); push(R_CG);
    push(I_CG); push(I_CG); push(I_CG);
    run_seq("");

    // R10 back-to-back frames
    seq_n = 0;
    push(I_CG); push(I_CG); push(J_CG); push(K_CG); push(enc(6)); push(T_CG); push(R_CG);
    push(J_CG); push(K_CG); push(enc(7)); push(enc(12)); push(T_CG); push(R_CG);
    push(I_CG); push(I_CG); push(I_CG);
    model();
    run_seq("");
    checks++; // R10 second frame starts at slot 7 with preamble
    if (exp_out[7] !== {4'b0101, 3'b101} || exp_out[9] !== {4'h7, 3'b101}) begin
      errors++;
      $display("FAIL R10: got %b expected %b", exp_out[7], {4'b0101, 3'b101});
    end

    report();
    $finish;
  end
endmodule